// File: doc/BRIEF.md
# GPIO Interrupt Sense Controller

This block watches 32 already-synchronized GPIO input levels and turns selected transitions or levels into interrupt requests. Each pin has a 4-bit sense code. The code chooses one of five detection modes: rising edge, falling edge, either edge, level high or level low. A fourth bit in the code chooses between fast detection, taken from the live input, and slower detection, taken from a registered copy one cycle later.

A detected event is held in a per-pin pending latch only when that pin's detection gate is open. Software clears a pending latch by writing a 1 to its bit. Pending bits are ANDed with per-pin enables to form a masked status word. Two request lines come from the masked status: one for pins 0–15 and one for pins 16–31.

Software reaches the block through a register request channel that uses valid/ready. `req_ready` is held high, so the block never applies back-pressure and accepts every request in the cycle it is presented. Each accepted read returns exactly one `rsp_valid` pulse one cycle later. That response cannot be stalled, so the requester must be able to take it. Writes produce no response.

Top module: `gsense_ctrl`

## Requirements
- R1: Writing a 1 to a bit at offset 0x18 sets that pin's enable, and writing a 1 at offset 0x1C clears it. Zero bits change nothing, and both offsets read back the current enable word.
- R2: The gate word at offset 0x14 is read/write. A pin whose gate bit is 0 latches no new event. Its existing pending state is kept.
- R3: Pin p's sense code is held in the register at offset 0x40 + 4*(p/8), in bits [4*(p%8)+3 : 4*(p%8)]. These four registers are read/write and reset to 0.
- R4: Code bits [2:0] select the detection mode: 0 = rising edge, 1 = falling edge, 2 = level high, 3 = level low, 4 = either edge. Values 5, 6 and 7 never produce an event.
- R5: With code bit 3 set, a pin change driven before a clock edge is pending right after that edge. With bit 3 clear, the pin becomes pending one edge later.
- R6: Writing a 1 to a bit at offset 0x28 clears that pin's pending latch. If an event arrives in the same cycle, the event wins. Offset 0x28 reads as 0, and pending bits fall only through this register.
- R7: In the level modes the pending latch sets on every cycle that the level is active, so it reads 1 again right after a clear.
- R8: Offset 0x20 returns the raw pending word. Offset 0x24 returns pending AND enable.
- R9: `irq_lo` is the OR of the masked status bits for pins 0–15. `irq_hi` is the OR of the masked status bits for pins 16–31.
- R10: After reset every register reads 0. `req_ready` is always 1. An accepted read gives one `rsp_valid` cycle on the next clock and no other cycle carries `rsp_valid`. Unmapped offsets read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 32 | Read data |
| pins_i | input | 32 | Synchronized pin levels |
| irq_lo | output | 1 | Request for pins 0–15 |
| irq_hi | output | 1 | Request for pins 16–31 |

## Verification
The bound checker checks these properties on every cycle:
- set and clear writes take effect on the enable word;
- a closed gate never lets a pending bit rise;
- pending bits fall only under a clear write;
- read responses keep their one-cycle timing;
- a request line is high only when some enabled pin in its half is pending.

The remaining behaviours can only be shown by the bench's scenarios:
- the decode of each sense code, including the three codes that detect nothing;
- the one-cycle latency difference between fast and slow detection;
- level modes setting again immediately after a clear;
- the nibble layout of the sense registers.

Random traffic is compared against a bench model for all of these.

// File: rtl/gsense_pkg.sv
package gsense_pkg;

  // Register byte offsets (software decodes these)
  localparam int unsigned ADR_GATE  = 'h14;
  localparam int unsigned ADR_ENSET = 'h18;
  localparam int unsigned ADR_ENCLR = 'h1C;
  localparam int unsigned ADR_RAW   = 'h20;
  localparam int unsigned ADR_MASK  = 'h24;
  localparam int unsigned ADR_PCLR  = 'h28;
  localparam int unsigned ADR_SNS0  = 'h40;

  localparam int unsigned CODE_W = 4;

  typedef enum logic [2:0] {
    DET_RISE = 3'd0,
    DET_FALL = 3'd1,
    DET_HIGH = 3'd2,
    DET_LOW  = 3'd3,
    DET_BOTH = 3'd4
  } det_mode_e;

  // Event decision for one pin given the chosen current/previous samples.
  function automatic logic det_hit(logic [2:0] mode, logic cur, logic prv);
    logic hit;
    case (mode)
      DET_RISE: hit = cur & ~prv;
      DET_FALL: hit = ~cur & prv;
      DET_HIGH: hit = cur;
      DET_LOW:  hit = ~cur;
      DET_BOTH: hit = cur ^ prv;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/gsense_detect.sv
module gsense_detect
  import gsense_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPINS-1:0]         pins_i,
  input  logic [CODE_W*NPINS-1:0]  sense_q,
  output logic [NPINS-1:0]         evt
);

  // Two history stages: the fast path compares live vs stage 1,
  // the slow path compares stage 1 vs stage 2.
  logic [NPINS-1:0] hist1_q;
  logic [NPINS-1:0] hist2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist1_q <= '0;
      hist2_q <= '0;
    end else begin
      hist1_q <= pins_i;
      hist2_q <= hist1_q;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [CODE_W-1:0] code;
    logic              fast;
    logic              cur;
    logic              prv;

    assign code = sense_q[p*CODE_W +: CODE_W];
    assign fast = code[CODE_W-1];
    assign cur  = fast ? pins_i[p]  : hist1_q[p];
    assign prv  = fast ? hist1_q[p] : hist2_q[p];
    assign evt[p] = det_hit(code[2:0], cur, prv);
  end

endmodule

// File: rtl/gsense_regs.sv
module gsense_regs
  import gsense_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [AW-1:0]            req_addr,
  input  logic [DW-1:0]            req_wdata,
  input  logic [NPINS-1:0]         evt,
  output logic                     rsp_valid,
  output logic [DW-1:0]            rsp_data,
  output logic [NPINS-1:0]         gate_q,
  output logic [NPINS-1:0]         en_q,
  output logic [NPINS-1:0]         pend_q,
  output logic [CODE_W*NPINS-1:0]  sense_q
);

  localparam int CODES_PER_REG = DW / CODE_W;
  localparam int NSREG         = NPINS / CODES_PER_REG;

  logic             wr_go;
  logic             rd_go;
  logic [NPINS-1:0] wmask;
  logic [NPINS-1:0] clr_mask;
  logic [DW-1:0]    rd_val;

  assign wr_go = req_valid &  req_write;
  assign rd_go = req_valid & ~req_write;
  assign wmask = req_wdata[NPINS-1:0];
  assign clr_mask = (wr_go && req_addr == AW'(ADR_PCLR)) ? wmask : '0;

  // Gate word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  gate_q <= '0;
    else if (wr_go && req_addr == AW'(ADR_GATE)) gate_q <= wmask;
  end

  // Enable word: write-1-set and write-1-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   en_q <= '0;
    else if (wr_go && req_addr == AW'(ADR_ENSET)) en_q <= en_q | wmask;
    else if (wr_go && req_addr == AW'(ADR_ENCLR)) en_q <= en_q & ~wmask;
  end

  // Pending latches: a gated event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | (evt & gate_q);
  end

  // Sense registers
  for (genvar r = 0; r < NSREG; r++) begin : g_sreg
    localparam int unsigned ADR_R = ADR_SNS0 + 4 * r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              sense_q[r*DW +: DW] <= '0;
      else if (wr_go && req_addr == AW'(ADR_R)) sense_q[r*DW +: DW] <= req_wdata;
    end
  end

  // Read mux
  always_comb begin
    rd_val = '0;
    if (req_addr == AW'(ADR_GATE))
      rd_val[NPINS-1:0] = gate_q;
    else if (req_addr == AW'(ADR_ENSET) || req_addr == AW'(ADR_ENCLR))
      rd_val[NPINS-1:0] = en_q;
    else if (req_addr == AW'(ADR_RAW))
      rd_val[NPINS-1:0] = pend_q;
    else if (req_addr == AW'(ADR_MASK))
      rd_val[NPINS-1:0] = pend_q & en_q;
    else begin
      for (int r = 0; r < NSREG; r++) begin
        if (req_addr == AW'(ADR_SNS0 + 4 * r)) rd_val = sense_q[r*DW +: DW];
      end
    end
  end

  // One-cycle read response, never stalled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_go;
      if (rd_go) rsp_data <= rd_val;
    end
  end

endmodule

// File: rtl/gsense_irq.sv
module gsense_irq #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] pend_q,
  input  logic [NPINS-1:0] en_q,
  output logic             irq_lo,
  output logic             irq_hi
);

  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0] live;

  assign live   = pend_q & en_q;
  assign irq_lo = |live[HALF-1:0];
  assign irq_hi = |live[NPINS-1:HALF];

endmodule

// File: rtl/gsense_ctrl.sv
module gsense_ctrl
  import gsense_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  input  logic [NPINS-1:0] pins_i,
  output logic             irq_lo,
  output logic             irq_hi
);

  logic [NPINS-1:0]        evt;
  logic [NPINS-1:0]        gate_q;
  logic [NPINS-1:0]        en_q;
  logic [NPINS-1:0]        pend_q;
  logic [CODE_W*NPINS-1:0] sense_q;

  assign req_ready = 1'b1;

  gsense_detect #(.NPINS(NPINS)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins_i  (pins_i),
    .sense_q (sense_q),
    .evt     (evt)
  );

  gsense_regs #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .evt       (evt),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .gate_q    (gate_q),
    .en_q      (en_q),
    .pend_q    (pend_q),
    .sense_q   (sense_q)
  );

  gsense_irq #(.NPINS(NPINS)) u_irq (
    .pend_q (pend_q),
    .en_q   (en_q),
    .irq_lo (irq_lo),
    .irq_hi (irq_hi)
  );

endmodule

// File: rtl/gsense_ctrl_chk.sv
module gsense_ctrl_chk
  import gsense_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [AW-1:0]    req_addr,
  input logic [DW-1:0]    req_wdata,
  input logic             rsp_valid,
  input logic [NPINS-1:0] gate_q,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] pend_q,
  input logic             irq_lo,
  input logic             irq_hi
);

  localparam int HALF = NPINS / 2;

  logic             wr_go;
  logic [NPINS-1:0] wbits;
  logic [NPINS-1:0] clr_now;

  assign wr_go   = req_valid & req_write;
  assign wbits   = req_wdata[NPINS-1:0];
  assign clr_now = (wr_go && req_addr == AW'(ADR_PCLR)) ? wbits : '0;

  p_enset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && req_addr == AW'(ADR_ENSET)) |=> ((en_q & $past(wbits)) == $past(wbits)));

  p_enclr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && req_addr == AW'(ADR_ENCLR)) |=> ((en_q & $past(wbits)) == '0));

  p_gate_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(gate_q)) == '0));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~pend_q & $past(pend_q) & ~$past(clr_now)) == '0));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && req_addr == AW'(ADR_PCLR) && gate_q == '0) |=> ((pend_q & $past(wbits)) == '0));

  p_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  p_norsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  p_irq_lo_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> ((pend_q[HALF-1:0] & en_q[HALF-1:0]) != '0));

  p_irq_hi_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> ((pend_q[NPINS-1:HALF] & en_q[NPINS-1:HALF]) != '0));

endmodule

bind gsense_ctrl gsense_ctrl_chk #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .gate_q    (gate_q),
  .en_q      (en_q),
  .pend_q    (pend_q),
  .irq_lo    (irq_lo),
  .irq_hi    (irq_hi)
);

// File: tb/gsense_ctrl_bench.sv
`timescale 1ns/1ps
module gsense_ctrl_bench;
  localparam int NPINS = 32;
  localparam int AW    = 8;
  localparam int DW    = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic             req_write = 1'b0;
  logic [AW-1:0]    req_addr = '0;
  logic [DW-1:0]    req_wdata = '0;
  logic             rsp_valid;
  logic [DW-1:0]    rsp_data;
  logic [NPINS-1:0] pins_i = '0;
  logic             irq_lo;
  logic             irq_hi;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  gsense_ctrl #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_gsense_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pins_i(pins_i),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // ---------------- reference model built from the requirements ----------------
  logic [NPINS-1:0] m_gate, m_en, m_pend, m_h1, m_h2;
  logic [3:0]       m_sns [NPINS];
  logic             m_rspv;
  logic [31:0]      m_rsp;
  string            m_tag;

  function automatic bit bm_evt(logic [3:0] code, bit live, bit h1, bit h2);
    bit c, pv;
    c  = code[3] ? live : h1;
    pv = code[3] ? h1 : h2;
    case (code[2:0])
      3'd0: return c & !pv;
      3'd1: return !c & pv;
      3'd2: return c;
      3'd3: return !c;
      3'd4: return c ^ pv;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      8'h14: v = m_gate;
      8'h18, 8'h1C: v = m_en;
      8'h20: v = m_pend;
      8'h24: v = m_pend & m_en;
      8'h40, 8'h44, 8'h48, 8'h4C:
        for (int k = 0; k < 8; k++) v[4*k +: 4] = m_sns[(a - 8'h40) * 2 + k];
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h14: return "R2 gate read";
      8'h18, 8'h1C: return "R1 enable read";
      8'h20, 8'h24: return "R8 status read";
      8'h28: return "R6 clear reads 0";
      8'h40, 8'h44, 8'h48, 8'h4C: return "R3 sense read";
      default: return "R10 unmapped read";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gate <= '0; m_en <= '0; m_pend <= '0; m_h1 <= '0; m_h2 <= '0;
      m_rspv <= 1'b0; m_rsp <= '0;
      for (int p = 0; p < NPINS; p++) m_sns[p] <= '0;
    end else begin
      logic [NPINS-1:0] ev, clr;
      for (int p = 0; p < NPINS; p++) ev[p] = bm_evt(m_sns[p], pins_i[p], m_h1[p], m_h2[p]);
      clr = (req_valid && req_write && req_addr == 8'h28) ? req_wdata : '0;
      m_pend <= (m_pend & ~clr) | (ev & m_gate);
      m_h1 <= pins_i;
      m_h2 <= m_h1;
      m_rspv <= req_valid && !req_write;
      if (req_valid && !req_write) begin
        m_rsp <= m_read(req_addr);
        m_tag <= tag_of(req_addr);
      end
      if (req_valid && req_write) begin
        case (req_addr)
          8'h14: m_gate <= req_wdata;
          8'h18: m_en <= m_en | req_wdata;
          8'h1C: m_en <= m_en & ~req_wdata;
          8'h40, 8'h44, 8'h48, 8'h4C:
            for (int k = 0; k < 8; k++) m_sns[(req_addr - 8'h40) * 2 + k] <= req_wdata[4*k +: 4];
          default: ;
        endcase
      end
    end
  end

  // Continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 rsp_valid timing", rsp_valid, m_rspv);
      check("R10 req_ready", req_ready, 1'b1);
      if (rsp_valid) check(m_tag, rsp_data, m_rsp);
      check("R9 irq_lo", irq_lo, |(m_pend[15:0] & m_en[15:0]));
      check("R9 irq_hi", irq_hi, |(m_pend[31:16] & m_en[31:16]));
    end
  end

  // ---------------- stimulus tasks (called at a negedge) ----------------
  task automatic wr(logic [7:0] a, logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_data;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] d1, d2, d3;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // Reset state (R10, R3)
    rd(8'h14, d1); check("R10 reset gate", d1, 0);
    rd(8'h18, d1); check("R10 reset enable", d1, 0);
    rd(8'h20, d1); check("R10 reset pending", d1, 0);
    rd(8'h4C, d1); check("R3 reset sense", d1, 0);

    // R1 set/clear enables
    wr(8'h18, 32'h0000_00F0); rd(8'h18, d1); check("R1 enable set", d1, 32'hF0);
    wr(8'h1C, 32'h0000_0030); rd(8'h1C, d1); check("R1 enable clear", d1, 32'hC0);
    wr(8'h1C, 32'hFFFF_FFFF);

    // R3 layout
    wr(8'h44, 32'h8765_4321); rd(8'h44, d1); check("R3 sense rw", d1, 32'h8765_4321);
    rd(8'h40, d1); check("R3 other sense untouched", d1, 0);
    wr(8'h44, 32'h0);

    // R5 fast path: pin0 code 8, pin1 code 0
    wr(8'h40, 32'h0000_0008); wr(8'h14, 32'h3);
    pins_i[0] = 1;
    rd(8'h20, d1); rd(8'h20, d2);
    check("R5 fast before edge", d1 & 1, 0);
    check("R5 fast pending after one edge", d2 & 1, 1);
    pins_i[1] = 1;
    rd(8'h20, d1); rd(8'h20, d2); rd(8'h20, d3);
    check("R5 slow not yet", (d2 >> 1) & 1, 0);
    check("R5 slow pending one edge later", (d3 >> 1) & 1, 1);

    // R6 clear
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h20, d1); check("R6 pending cleared", d1, 0);
    rd(8'h28, d1); check("R6 clear reads 0", d1, 0);

    // R4 modes: pin2 fall, pin3 both, pin4 code 5
    wr(8'h40, 32'h0005_4108); wr(8'h14, 32'h1F); wr(8'h28, 32'hFFFF_FFFF);
    pins_i[4:2] = 3'b111; idle(3);
    rd(8'h20, d1); check("R4 rise seen by both-edge only", d1, 32'h08);
    wr(8'h28, 32'hFFFF_FFFF);
    pins_i[4:2] = 3'b000; idle(3);
    rd(8'h20, d1); check("R4 fall and both-edge, code 5 silent", d1, 32'h0C);
    wr(8'h28, 32'hFFFF_FFFF);

    // R7 levels: pin5 high, pin6 low
    wr(8'h40, 32'h0325_4108); wr(8'h14, 32'h7F);
    pins_i[5] = 1; idle(3);
    rd(8'h20, d1); check("R7 both levels pending", d1, 32'h60);
    wr(8'h28, 32'h60);
    rd(8'h20, d1); check("R7 level sets again after clear", d1, 32'h60);
    pins_i[5] = 0; pins_i[6] = 1; idle(3);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h20, d1); check("R7 inactive level stays clear", d1, 0);

    // R2 gate closed
    pins_i[5] = 1;
    wr(8'h14, 32'h0); wr(8'h28, 32'hFFFF_FFFF); idle(2);
    rd(8'h20, d1); check("R2 closed gate latches nothing", d1, 0);

    // R8 / R9
    wr(8'h48, 32'h0002_0000); pins_i[20] = 1;
    wr(8'h14, 32'h0010_0020); idle(2);
    rd(8'h20, d1); check("R8 raw pending", d1, 32'h0010_0020);
    check("R9 no enable no irq", {30'b0, irq_hi, irq_lo}, 0);
    wr(8'h18, 32'h20);
    check("R9 low half irq", {30'b0, irq_hi, irq_lo}, 1);
    rd(8'h24, d1); check("R8 masked status", d1, 32'h20);
    wr(8'h18, 32'h0010_0000);
    check("R9 high half irq", {30'b0, irq_hi, irq_lo}, 3);
    wr(8'h1C, 32'hFFFF_FFFF);
    check("R1 clear drops both irqs", {30'b0, irq_hi, irq_lo}, 0);

    // R10 unmapped
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, d1); check("R10 unmapped reads 0", d1, 0);
    rd(8'h14, d1); check("R10 unmapped write ignored", d1, 32'h0010_0020);

    // Constrained random phase, compared continuously against the model
    for (int i = 0; i < 6000; i++) begin
      int op;
      logic [7:0] a;
      if ($urandom_range(3) == 0) pins_i = pins_i ^ ($urandom & $urandom & $urandom);
      op = $urandom_range(9);
      case (op)
        0: wr(8'h14, $urandom);
        1: wr(8'h18, $urandom & $urandom);
        2: wr(8'h1C, $urandom & $urandom);
        3: wr(8'h28, $urandom);
        4: wr(8'h40 + 8'($urandom_range(3) * 4), $urandom);
        5: wr(8'($urandom_range(255)) & 8'hFC, $urandom);
        6, 7: begin
          case ($urandom_range(4))
            0: a = 8'h20; 1: a = 8'h24; 2: a = 8'h18;
            3: a = 8'h40 + 8'($urandom_range(3) * 4);
            default: a = 8'($urandom_range(255)) & 8'hFC;
          endcase
          rd(a, d1);
        end
        default: idle(1);
      endcase
    end
    idle(2);
    finish_run();
  end

endmodule